// File: doc/BRIEF.md
# Hysteresis Supply Switch Controller

This block decides when a supply shunt switch conducts so that the chip supply stays inside a hysteresis window while the chip is in operating mode. Three comparator flags report where the supply sits: above a protection level, above the regulator on-level, or below the regulator off-level. The controller also watches the low-side half-bridge command, and it changes the switch only on falling edges of that command. This keeps the switching aligned with the half-bridge cycle.

One exception to edge alignment exists. When the supply rises above the protection level, the switch closes at the next clock edge without waiting for the half-bridge. When operating mode begins, the controller first lets a set number of falling edges pass before the on-level and off-level flags take effect. The mode sequencer gates the block with an enable. While the enable is low, the switch is held open and the edge count restarts.

Top module: `tprSwitchCtrl`

## Requirements
- R1: During reset, and in the first cycle after reset, `switchOn` is 0.
- R2: At the first clock edge where `enable` is sampled low, `switchOn` becomes 0. It stays 0 while `enable` is low, and the count of arming edges restarts from zero.
- R3: When `enable` and `vccOverProt` are both sampled high at a clock edge, `switchOn` is 1 after that edge. No falling edge of `lowSideIn` is needed, and the arming count does not matter.
- R4: At an armed falling edge with `vccOverProt` low and `vccAboveOn` high, `switchOn` becomes 1.
- R5: At an armed falling edge with `vccOverProt` low, `vccAboveOn` low and `vccBelowOff` high, `switchOn` becomes 0.
- R6: `switchOn` keeps its value while enabled when there is no falling edge and `vccOverProt` is low. It also keeps its value at an armed falling edge where all three flags are low.
- R7: After `enable` rises, the first ARM_EDGES falling edges (default 1) only count toward arming and do not act on `vccAboveOn` or `vccBelowOff`. Every later falling edge is armed.
- R8: A falling edge is a clock edge where `lowSideIn` is sampled 0 and was sampled 1 at the clock edge before. A rising edge or a steady level has no effect.
- R9: `vccAboveOn` and `vccBelowOff` are never high in the same cycle (input rule).
- R10: While `enable` is low, `vccOverProt` has no effect and `switchOn` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High while the mode sequencer is in operating mode |
| vccOverProt | input | 1 | Supply above the protection level |
| vccAboveOn | input | 1 | Supply above the regulator on-level |
| vccBelowOff | input | 1 | Supply below the regulator off-level |
| lowSideIn | input | 1 | Low-side half-bridge command |
| switchOn | output | 1 | Shunt switch closed when 1 |

## Verification
On every cycle, the assertions check the following:
- the switch opens when the block is disabled and closes on protection;
- every rise of `switchOn` can be traced to protection or to an on-level falling edge;
- every fall of `switchOn` can be traced to disable or to an off-level falling edge;
- the output holds between edges;
- the on-level and off-level flags are never high together.

Only the bench scenarios can show the arming count. They show that the first falling edge after enable is ignored, that disabling restarts the count, and that a rising edge does nothing.

// File: rtl/tprSwitchPkg.sv
package tprSwitchPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic forceOff;  // enable low: open the switch
    logic setSw;     // close the switch
    logic clrSw;     // open the switch
  } tprStrobeT;
endpackage

// File: rtl/tprSwitchDatapath.sv
module tprSwitchDatapath
  import tprSwitchPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      lowSideIn,
  input  tprStrobeT strb,
  output logic      lowFall,
  output logic      switchOn
);
  logic lowQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowQ <= 1'b0;
    else       lowQ <= lowSideIn;
  end

  assign lowFall = lowQ & ~lowSideIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             switchOn <= 1'b0;
    else if (strb.forceOff) switchOn <= 1'b0;
    else if (strb.setSw)    switchOn <= 1'b1;
    else if (strb.clrSw)    switchOn <= 1'b0;
  end
endmodule

// File: rtl/tprSwitchControl.sv
module tprSwitchControl
  import tprSwitchPkg::*;
#(
  parameter int ARM_EDGES = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      vccOverProt,
  input  logic      vccAboveOn,
  input  logic      vccBelowOff,
  input  logic      lowFall,
  output tprStrobeT strb
);
  localparam int CW = $clog2(ARM_EDGES + 2);
  localparam logic [CW-1:0] ARM_LIMIT = CW'(ARM_EDGES);

  logic [CW-1:0] edgeCnt;
  logic          armed;

  assign armed = (edgeCnt == ARM_LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  edgeCnt <= '0;
    else if (!enable)           edgeCnt <= '0;
    else if (lowFall && !armed) edgeCnt <= edgeCnt + 1'b1;
  end

  always_comb begin
    strb = '0;
    if (!enable) begin
      strb.forceOff = 1'b1;
    end else if (vccOverProt) begin
      strb.setSw = 1'b1;
    end else if (lowFall && armed) begin
      if (vccAboveOn)       strb.setSw = 1'b1;
      else if (vccBelowOff) strb.clrSw = 1'b1;
    end
  end
endmodule

// File: rtl/tprSwitchCtrl.sv
module tprSwitchCtrl
  import tprSwitchPkg::*;
#(
  parameter int ARM_EDGES = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic vccOverProt,
  input  logic vccAboveOn,
  input  logic vccBelowOff,
  input  logic lowSideIn,
  output logic switchOn
);
  tprStrobeT strb;
  logic      lowFall;

  tprSwitchControl #(.ARM_EDGES(ARM_EDGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .vccOverProt(vccOverProt), .vccAboveOn(vccAboveOn),
    .vccBelowOff(vccBelowOff), .lowFall(lowFall), .strb(strb)
  );

  tprSwitchDatapath u_dp (
    .clk(clk), .rstN(rstN), .lowSideIn(lowSideIn),
    .strb(strb), .lowFall(lowFall), .switchOn(switchOn)
  );
endmodule

// File: rtl/tprSwitchCtrl_chk.sv
module tprSwitchCtrl_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic vccOverProt,
  input logic vccAboveOn,
  input logic vccBelowOff,
  input logic lowSideIn,
  input logic switchOn
);
  logic lowPrev;
  logic seenFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowPrev <= 1'b0;
    else       lowPrev <= lowSideIn;
  end

  assign seenFall = lowPrev && !lowSideIn;

  // R2
  disable_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !switchOn);

  // R3
  prot_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && vccOverProt) |=> switchOn);

  // R4
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!switchOn && !(enable && (vccOverProt || (seenFall && vccAboveOn)))) |=> !switchOn);

  // R5
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (switchOn && enable && !(seenFall && vccBelowOff)) |=> switchOn);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !vccOverProt && !seenFall) |=> $stable(switchOn));

  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(vccAboveOn && vccBelowOff));
endmodule

bind tprSwitchCtrl tprSwitchCtrl_chk u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .vccOverProt(vccOverProt),
  .vccAboveOn(vccAboveOn), .vccBelowOff(vccBelowOff),
  .lowSideIn(lowSideIn), .switchOn(switchOn)
);

// File: tb/tprSwitchCtrl_tb.sv
module tprSwitchCtrl_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic vccOverProt = 1'b0;
  logic vccAboveOn = 1'b0;
  logic vccBelowOff = 1'b0;
  logic lowSideIn = 1'b0;
  logic switchOn;

  int checks = 0;
  int errors = 0;
  logic  expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  tprSwitchCtrl u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .vccOverProt(vccOverProt),
    .vccAboveOn(vccAboveOn), .vccBelowOff(vccBelowOff),
    .lowSideIn(lowSideIn), .switchOn(switchOn)
  );

  // Driver: apply inputs at negedge, queue the value expected after next posedge
  task automatic cyc(input logic en, input logic op, input logic on,
                     input logic off, input logic ls, input logic exp,
                     input string tag);
    @(negedge clk);
    enable = en; vccOverProt = op; vccAboveOn = on;
    vccBelowOff = off; lowSideIn = ls;
    expQ.push_back(exp);
    tagQ.push_back(tag);
  endtask

  // Monitor: compare shortly after each rising edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      logic  e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (switchOn !== e) begin
        errors++;
        $display("FAIL %s: switchOn=%b expected=%b", t, switchOn, e);
      end
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #23;
    checks++;
    if (switchOn !== 1'b0) begin
      errors++;
      $display("FAIL R1: switchOn=%b expected=0 in reset", switchOn);
    end
    rstN = 1'b1;
    cyc(0,0,0,0,0, 0, "R1");
    // arming: first fall does not act (R7), rising edge no effect (R8)
    cyc(1,0,1,0,1, 0, "R7");
    cyc(1,0,1,0,0, 0, "R7");
    cyc(1,0,1,0,1, 0, "R8");
    cyc(1,0,1,0,0, 1, "R4");
    // hold with no flags at armed edge
    cyc(1,0,0,0,1, 1, "R6");
    cyc(1,0,0,0,0, 1, "R6");
    // off-level without an edge holds
    cyc(1,0,0,1,1, 1, "R6");
    cyc(1,0,0,1,1, 1, "R6");
    cyc(1,0,0,1,0, 0, "R5");
    // protection closes at once
    cyc(1,1,0,0,0, 1, "R3");
    cyc(1,0,0,0,0, 1, "R6");
    // disable opens and restarts arming
    cyc(0,0,0,0,0, 0, "R2");
    cyc(1,0,1,0,1, 0, "R2");
    cyc(1,0,1,0,0, 0, "R7");
    cyc(1,0,1,0,1, 0, "R8");
    cyc(1,0,1,0,0, 1, "R4");
    // protection ignored when disabled
    cyc(0,1,0,0,0, 0, "R10");
    cyc(0,1,0,0,0, 0, "R10");
    // protection acts before arming
    cyc(1,1,0,0,0, 1, "R3");
    cyc(1,0,0,0,0, 1, "R6");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule